// File: doc/BRIEF.md
# Word DMA Engine

The engine moves a burst of 16-bit words between an external parallel device and system memory. Before a burst, control logic writes four settings through a small write port: the lower and upper parts of a word address, a range count, and an address-modifier code. A `go` pulse then starts the burst. The burst direction comes from an external control input, or from a function latch when link mode is selected.

For each word, the engine makes one memory access and one device transfer. It advances the word address by one and counts the range down. After the word moved while the range is zero, it raises end-of-range and returns to ready. An attention pulse from the device cuts a burst short and raises both the attention flag and the end-of-range flag. Memory parity errors, bus errors and access timeouts each set their own sticky flag. These flags, together with the last data word, can be read after the burst.

Back-pressure rules:
- Memory requests, device output and device input are each valid/ready pairs.
- A memory request stays valid with its address, direction and write data unchanged until `mem_req_ready` is seen.
- Read data and error indications are sampled in the cycle of the handshake.
- Device output holds its data until accepted.
- Device input is taken in the cycle where `dev_in_valid` meets `dev_in_ready`.
- A word takes at least two cycles: one for the memory side and one for the device side.

Top module: `word_dma_engine`

## Requirements
- R1: The memory byte address is {upper part (15 bits), lower part (16 bits), 1'b0}. Write selects on `cfg_sel`: 0 = lower address part, 1 = upper address part, 2 = range, 3 = address modifier (6 bits). Every memory access drives the current modifier on `mem_req_amod`.
- R2: A range value of N moves exactly N+1 words. Each access uses a byte address 2 higher than the previous one, and the carry passes from the lower part into the upper part. The final word does not advance the counters, so the range reads 0 and the address points at the final word.
- R3: After a complete burst, `ready` and `eor_flag` are both 1.
- R4: At `go`, the direction is taken from `fn1_latch` when `link_mode` is 1, otherwise from `ext_dir`. A direction of 1 means device to memory: device input is followed by a memory write. A direction of 0 means memory to device: a memory read is followed by device output.
- R5: `attn` high during a burst ends the burst at that edge and sets `attn_flag` and `eor_flag`.
- R6: After a memory-to-device burst, `last_word` holds the last word sent to the device.
- R7: A memory request waiting for ready keeps its address, modifier, direction and write data. A device output waiting for ready keeps its data.
- R8: If a memory request sees no ready for 64 consecutive cycles, the engine sets `tmo_flag` and ends the burst without setting `eor_flag`.
- R9: A bus error at a memory handshake sets `berr_flag` and ends the burst without end-of-range. A parity error sets `perr_flag` and the burst continues.
- R10: While a burst runs, `go` and setting writes have no effect. A `go` accepted in ready clears all five flags.
- R11: After reset, `ready` is 1, all flags are 0, no valid or ready output is asserted, and address, range and modifier are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Setting write strobe (honoured only when ready) |
| cfg_sel | input | 2 | Setting select: 0 addr low, 1 addr high, 2 range, 3 modifier |
| cfg_wdata | input | 16 | Setting write value |
| go | input | 1 | Start a burst |
| ext_dir | input | 1 | Direction control from the device cable |
| link_mode | input | 1 | Take direction from the function latch instead |
| fn1_latch | input | 1 | Function latch 1 (1 = device to memory) |
| attn | input | 1 | Attention pulse from the device |
| mem_req_valid | output | 1 | Memory access request |
| mem_req_ready | input | 1 | Memory accepts / completes the access |
| mem_req_write | output | 1 | 1 = write to memory |
| mem_req_addr | output | 32 | Byte address |
| mem_req_amod | output | 6 | Address modifier |
| mem_req_wdata | output | 16 | Write data |
| mem_rsp_rdata | input | 16 | Read data, valid at handshake |
| mem_rsp_perr | input | 1 | Parity error, valid at handshake |
| mem_rsp_berr | input | 1 | Bus error, valid at handshake |
| dev_in_valid | input | 1 | Device offers a word |
| dev_in_ready | output | 1 | Engine takes a device word |
| dev_in_data | input | 16 | Word from the device |
| dev_out_valid | output | 1 | Engine offers a word to the device |
| dev_out_ready | input | 1 | Device accepts the word |
| dev_out_data | output | 16 | Word to the device |
| ready | output | 1 | Engine idle |
| eor_flag | output | 1 | End of range reached |
| attn_flag | output | 1 | Attention seen |
| perr_flag | output | 1 | Parity error seen |
| berr_flag | output | 1 | Bus error seen |
| tmo_flag | output | 1 | Memory access timed out |
| last_word | output | 16 | Data holding register |
| words_left | output | 16 | Current range count |

## Verification
A corrupted address counter shows up on `mem_req_addr` at the next memory request, one word after the fault. The bench compares every request against the expected 2-byte stride. A wrong range count shows up at the end of the burst: the engine returns to `ready` one word too early or too late, or `words_left` is non-zero afterwards. A faulty wait timer moves the point where `tmo_flag` rises away from the 64th waiting cycle. A faulty staging register shows up in the device data or memory write data of the same word.

// File: rtl/wdma_pkg.sv
package wdma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_SEND,
    ST_ACCEPT,
    ST_STORE
  } wdma_state_e;

  localparam logic [1:0] SEL_ADDR_LO = 2'd0;
  localparam logic [1:0] SEL_ADDR_HI = 2'd1;
  localparam logic [1:0] SEL_RANGE   = 2'd2;
  localparam logic [1:0] SEL_AMOD    = 2'd3;
endpackage

// File: rtl/wdma_addr_range.sv
module wdma_addr_range
  import wdma_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int LO_W    = 16,
  parameter int HI_W    = 15,
  parameter int RANGE_W = 16,
  parameter int AMOD_W  = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [1:0]             wr_sel,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic                   step,
  output logic [LO_W+HI_W:0]     byte_addr,
  output logic [RANGE_W-1:0]     range_q,
  output logic [AMOD_W-1:0]      amod_q,
  output logic                   range_zero
);
  localparam int WA_W = LO_W + HI_W;
  localparam logic [WA_W-1:0]    WA_ONE = 1;
  localparam logic [RANGE_W-1:0] RG_ONE = 1;

  logic [WA_W-1:0] waddr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waddr_q <= '0;
      range_q <= '0;
      amod_q  <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_ADDR_LO: waddr_q[LO_W-1:0]    <= wr_data[LO_W-1:0];
        SEL_ADDR_HI: waddr_q[WA_W-1:LO_W] <= wr_data[HI_W-1:0];
        SEL_RANGE:   range_q              <= wr_data[RANGE_W-1:0];
        default:     amod_q               <= wr_data[AMOD_W-1:0];
      endcase
    end else if (step) begin
      waddr_q <= waddr_q + WA_ONE;
      range_q <= range_q - RG_ONE;
    end
  end

  assign byte_addr  = {waddr_q, 1'b0};
  assign range_zero = (range_q == '0);
endmodule

// File: rtl/wdma_wait_timer.sv
module wdma_wait_timer #(
  parameter int TMO_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic waiting,
  output logic expire
);
  localparam int CNT_W = $clog2(TMO_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TMO_CYCLES - 1);
  localparam logic [CNT_W-1:0] ONE  = 1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!waiting) cnt_q <= '0;
    else               cnt_q <= cnt_q + ONE;
  end

  assign expire = waiting && (cnt_q == LAST);
endmodule

// File: rtl/wdma_ctrl.sv
module wdma_ctrl
  import wdma_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              dir_sel,
  input  logic              attn,
  input  logic              range_zero,
  input  logic              tmo_expire,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_perr,
  input  logic              mem_berr,
  input  logic              din_valid,
  input  logic [DATA_W-1:0] din_data,
  input  logic              dout_ready,
  output logic              idle,
  output logic              mem_valid,
  output logic              mem_write,
  output logic              din_ready,
  output logic              dout_valid,
  output logic              step,
  output logic [DATA_W-1:0] data_q,
  output logic              eor_q,
  output logic              attn_q,
  output logic              perr_q,
  output logic              berr_q,
  output logic              tmo_q
);
  wdma_state_e state_q;

  assign idle       = (state_q == ST_IDLE);
  assign mem_valid  = (state_q == ST_FETCH) || (state_q == ST_STORE);
  assign mem_write  = (state_q == ST_STORE);
  assign din_ready  = (state_q == ST_ACCEPT);
  assign dout_valid = (state_q == ST_SEND);

  always_comb begin
    step = 1'b0;
    if (!attn && !range_zero) begin
      if (state_q == ST_SEND && dout_ready) step = 1'b1;
      if (state_q == ST_STORE && mem_ready && !mem_berr) step = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      data_q  <= '0;
      eor_q   <= 1'b0;
      attn_q  <= 1'b0;
      perr_q  <= 1'b0;
      berr_q  <= 1'b0;
      tmo_q   <= 1'b0;
    end else if (state_q == ST_IDLE) begin
      if (go) begin
        eor_q   <= 1'b0;
        perr_q  <= 1'b0;
        berr_q  <= 1'b0;
        tmo_q   <= 1'b0;
        attn_q  <= attn;
        state_q <= dir_sel ? ST_ACCEPT : ST_FETCH;
      end else if (attn) begin
        attn_q <= 1'b1;
      end
    end else if (attn) begin
      attn_q  <= 1'b1;
      eor_q   <= 1'b1;
      state_q <= ST_IDLE;
    end else begin
      case (state_q)
        ST_FETCH: begin
          if (mem_ready) begin
            data_q <= mem_rdata;
            if (mem_perr) perr_q <= 1'b1;
            if (mem_berr) begin
              berr_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_SEND;
            end
          end else if (tmo_expire) begin
            tmo_q   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_SEND: begin
          if (dout_ready) begin
            if (range_zero) begin
              eor_q   <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_FETCH;
            end
          end
        end
        ST_ACCEPT: begin
          if (din_valid) begin
            data_q  <= din_data;
            state_q <= ST_STORE;
          end
        end
        ST_STORE: begin
          if (mem_ready) begin
            if (mem_perr) perr_q <= 1'b1;
            if (mem_berr) begin
              berr_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else if (range_zero) begin
              eor_q   <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_ACCEPT;
            end
          end else if (tmo_expire) begin
            tmo_q   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/word_dma_engine.sv
module word_dma_engine #(
  parameter int DATA_W     = 16,
  parameter int LO_W       = 16,
  parameter int HI_W       = 15,
  parameter int RANGE_W    = 16,
  parameter int AMOD_W     = 6,
  parameter int TMO_CYCLES = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_wr,
  input  logic [1:0]            cfg_sel,
  input  logic [DATA_W-1:0]     cfg_wdata,
  input  logic                  go,
  input  logic                  ext_dir,
  input  logic                  link_mode,
  input  logic                  fn1_latch,
  input  logic                  attn,
  output logic                  mem_req_valid,
  input  logic                  mem_req_ready,
  output logic                  mem_req_write,
  output logic [LO_W+HI_W:0]    mem_req_addr,
  output logic [AMOD_W-1:0]     mem_req_amod,
  output logic [DATA_W-1:0]     mem_req_wdata,
  input  logic [DATA_W-1:0]     mem_rsp_rdata,
  input  logic                  mem_rsp_perr,
  input  logic                  mem_rsp_berr,
  input  logic                  dev_in_valid,
  output logic                  dev_in_ready,
  input  logic [DATA_W-1:0]     dev_in_data,
  output logic                  dev_out_valid,
  input  logic                  dev_out_ready,
  output logic [DATA_W-1:0]     dev_out_data,
  output logic                  ready,
  output logic                  eor_flag,
  output logic                  attn_flag,
  output logic                  perr_flag,
  output logic                  berr_flag,
  output logic                  tmo_flag,
  output logic [DATA_W-1:0]     last_word,
  output logic [RANGE_W-1:0]    words_left
);
  logic idle, step, range_zero, tmo_expire, dir_sel;
  logic [DATA_W-1:0] data_q;

  assign dir_sel = link_mode ? fn1_latch : ext_dir;

  wdma_addr_range #(
    .DATA_W(DATA_W), .LO_W(LO_W), .HI_W(HI_W),
    .RANGE_W(RANGE_W), .AMOD_W(AMOD_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_wr && idle), .wr_sel(cfg_sel), .wr_data(cfg_wdata),
    .step(step),
    .byte_addr(mem_req_addr), .range_q(words_left), .amod_q(mem_req_amod),
    .range_zero(range_zero)
  );

  wdma_wait_timer #(.TMO_CYCLES(TMO_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .waiting(mem_req_valid && !mem_req_ready),
    .expire(tmo_expire)
  );

  wdma_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .go(go), .dir_sel(dir_sel), .attn(attn),
    .range_zero(range_zero), .tmo_expire(tmo_expire),
    .mem_ready(mem_req_ready), .mem_rdata(mem_rsp_rdata),
    .mem_perr(mem_rsp_perr), .mem_berr(mem_rsp_berr),
    .din_valid(dev_in_valid), .din_data(dev_in_data),
    .dout_ready(dev_out_ready),
    .idle(idle), .mem_valid(mem_req_valid), .mem_write(mem_req_write),
    .din_ready(dev_in_ready), .dout_valid(dev_out_valid),
    .step(step), .data_q(data_q),
    .eor_q(eor_flag), .attn_q(attn_flag), .perr_q(perr_flag),
    .berr_q(berr_flag), .tmo_q(tmo_flag)
  );

  assign ready         = idle;
  assign mem_req_wdata = data_q;
  assign dev_out_data  = data_q;
  assign last_word     = data_q;
endmodule

// File: rtl/wdma_checker.sv
module wdma_checker #(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 32,
  parameter int AMOD_W     = 6,
  parameter int TMO_CYCLES = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ready,
  input logic              attn,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [AMOD_W-1:0] mem_req_amod,
  input logic [DATA_W-1:0] mem_req_wdata,
  input logic              dev_out_valid,
  input logic              dev_out_ready,
  input logic [DATA_W-1:0] dev_out_data,
  input logic              dev_in_ready,
  input logic              eor_flag,
  input logic              attn_flag,
  input logic              tmo_flag
);
  localparam int W_W = $clog2(TMO_CYCLES + 1) + 1;
  localparam logic [W_W-1:0] W_LAST = W_W'(TMO_CYCLES - 1);
  localparam logic [W_W-1:0] W_ONE  = 1;

  logic [W_W-1:0] wait_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)                              wait_cnt <= '0;
    else if (mem_req_valid && !mem_req_ready) wait_cnt <= wait_cnt + W_ONE;
    else                                      wait_cnt <= '0;
  end

  // R11: nothing requested or offered while idle
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (!mem_req_valid && !dev_out_valid && !dev_in_ready));

  a_r7_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready && !attn && wait_cnt != W_LAST)
    |=> (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_wdata)
         && $stable(mem_req_write)));

  a_r7_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_out_valid && !dev_out_ready && !attn)
    |=> (dev_out_valid && $stable(dev_out_data)));

  a_r8_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready && !attn && wait_cnt == W_LAST)
    |=> (tmo_flag && ready && !eor_flag));

  a_r5_attn_end: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && attn) |=> (ready && eor_flag && attn_flag));

  a_r10_amod_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> $stable(mem_req_amod));
endmodule

bind word_dma_engine wdma_checker #(
  .DATA_W(DATA_W), .ADDR_W(LO_W + HI_W + 1),
  .AMOD_W(AMOD_W), .TMO_CYCLES(TMO_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .attn(attn),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
  .mem_req_amod(mem_req_amod), .mem_req_wdata(mem_req_wdata),
  .dev_out_valid(dev_out_valid), .dev_out_ready(dev_out_ready),
  .dev_out_data(dev_out_data), .dev_in_ready(dev_in_ready),
  .eor_flag(eor_flag), .attn_flag(attn_flag), .tmo_flag(tmo_flag)
);

// File: tb/sim_word_dma_engine.sv
module sim_word_dma_engine;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        dir;
    logic [15:0] lo;
    logic [14:0] hi;
    logic [15:0] rng;
    logic [5:0]  amod;
    logic [3:0]  stall;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{1'b0, 16'h0100, 15'h0000, 16'd0, 6'h3D, 4'd0},
    '{1'b0, 16'hFFFE, 15'h0001, 16'd3, 6'h09, 4'd2},
    '{1'b1, 16'h0040, 15'h7FFF, 16'd2, 6'h0D, 4'd1},
    '{1'b1, 16'h0000, 15'h0000, 16'd5, 6'h3F, 4'd0}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_wr;
  logic [1:0] cfg_sel;
  logic [15:0] cfg_wdata;
  logic go, ext_dir, link_mode, fn1_latch, attn;
  logic mem_req_valid, mem_req_ready, mem_req_write;
  logic [31:0] mem_req_addr;
  logic [5:0] mem_req_amod;
  logic [15:0] mem_req_wdata, mem_rsp_rdata;
  logic mem_rsp_perr, mem_rsp_berr;
  logic dev_in_valid, dev_in_ready;
  logic [15:0] dev_in_data;
  logic dev_out_valid, dev_out_ready;
  logic [15:0] dev_out_data;
  logic ready, eor_flag, attn_flag, perr_flag, berr_flag, tmo_flag;
  logic [15:0] last_word, words_left;

  word_dma_engine u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .go(go), .ext_dir(ext_dir), .link_mode(link_mode),
    .fn1_latch(fn1_latch), .attn(attn), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_amod(mem_req_amod),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_rdata(mem_rsp_rdata),
    .mem_rsp_perr(mem_rsp_perr), .mem_rsp_berr(mem_rsp_berr),
    .dev_in_valid(dev_in_valid), .dev_in_ready(dev_in_ready),
    .dev_in_data(dev_in_data), .dev_out_valid(dev_out_valid),
    .dev_out_ready(dev_out_ready), .dev_out_data(dev_out_data),
    .ready(ready), .eor_flag(eor_flag), .attn_flag(attn_flag),
    .perr_flag(perr_flag), .berr_flag(berr_flag), .tmo_flag(tmo_flag),
    .last_word(last_word), .words_left(words_left)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] base;
  logic [5:0]  exp_amod;
  int r_words, r_wr, r_addr_err, r_amod_err, r_data_err, r_vcyc;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mem_word(input logic [31:0] a);
    return a[16:1] ^ 16'h5A3C;
  endfunction

  function automatic logic [15:0] dev_word(input int i);
    return 16'hC000 + i[15:0];
  endfunction

  task automatic clear_inputs();
    cfg_wr = 0; go = 0; attn = 0;
    mem_req_ready = 0; mem_rsp_perr = 0; mem_rsp_berr = 0; mem_rsp_rdata = 0;
    dev_in_valid = 0; dev_in_data = 0; dev_out_ready = 0;
  endtask

  task automatic cfg_write(input logic [1:0] s, input logic [15:0] d);
    cfg_sel = s; cfg_wdata = d; cfg_wr = 1;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic setup(input logic [15:0] lo, input logic [14:0] hi,
                       input logic [15:0] rng, input logic [5:0] amod);
    cfg_write(2'd0, lo);
    cfg_write(2'd1, {1'b0, hi});
    cfg_write(2'd2, rng);
    cfg_write(2'd3, {10'd0, amod});
    base = {hi, lo, 1'b0};
    exp_amod = amod;
  endtask

  task automatic run(input int stall, input int berr_at, input int perr_at,
                     input int attn_at, input int poke_at);
    int w;
    w = 0;
    r_words = 0; r_wr = 0; r_addr_err = 0; r_amod_err = 0; r_data_err = 0; r_vcyc = 0;
    go = 1;
    @(negedge clk);
    go = 0;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      if (ready) break;
      clear_inputs();
      if (mem_req_valid) r_vcyc++;
      if (cyc == attn_at) begin
        attn = 1;
      end else begin
        if (cyc == poke_at) begin
          go = 1; cfg_wr = 1; cfg_sel = 2'd3; cfg_wdata = 16'h0011;
        end
        if (mem_req_valid) begin
          if (mem_req_addr !== base + 32'(2 * r_words)) r_addr_err++;
          if (mem_req_amod !== exp_amod) r_amod_err++;
          if (w >= stall) begin
            w = 0;
            mem_req_ready = 1;
            mem_rsp_rdata = mem_word(mem_req_addr);
            if (r_words == berr_at) mem_rsp_berr = 1;
            if (r_words == perr_at) mem_rsp_perr = 1;
            if (mem_req_write) begin
              if (mem_req_wdata !== dev_word(r_words)) r_data_err++;
              r_wr++;
              r_words++;
            end
          end else begin
            w++;
          end
        end
        if (dev_out_valid) begin
          dev_out_ready = 1;
          if (dev_out_data !== mem_word(base + 32'(2 * r_words))) r_data_err++;
          r_words++;
        end
        if (dev_in_ready) begin
          dev_in_valid = 1;
          dev_in_data = dev_word(r_words);
        end
      end
      @(negedge clk);
    end
    clear_inputs();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog R3 actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    vec_t v;
    rst_n = 0; ext_dir = 0; link_mode = 0; fn1_latch = 0;
    cfg_sel = 0; cfg_wdata = 0;
    clear_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    check("R11 ready", 32'(ready), 1);
    check("R11 flags", {27'd0, eor_flag, attn_flag, perr_flag, berr_flag, tmo_flag}, 0);
    check("R11 handshakes", {29'd0, mem_req_valid, dev_out_valid, dev_in_ready}, 0);
    check("R11 addr", mem_req_addr, 0);
    check("R11 range/amod", {words_left, 10'd0, mem_req_amod}, 0);

    // vector table: R1, R2, R3, R4, R6, R7
    for (int i = 0; i < 4; i++) begin
      v = VECS[i];
      ext_dir = v.dir;
      setup(v.lo, v.hi, v.rng, v.amod);
      run(int'(v.stall), -1, -1, -1, -1);
      check("R2 word count", r_words, 32'(v.rng) + 1);
      check("R1 R7 address sequence errors", r_addr_err, 0);
      check("R1 modifier errors", r_amod_err, 0);
      check("R3 ready+eor", {30'd0, ready, eor_flag}, 3);
      check("R2 range left", 32'(words_left), 0);
      check("R2 final address", mem_req_addr, base + 32'(2 * v.rng));
      check("R4 data path errors", r_data_err, 0);
      if (v.dir) check("R4 memory writes", r_wr, 32'(v.rng) + 1);
      else begin
        check("R4 no memory writes", r_wr, 0);
        check("R6 last word", 32'(last_word), 32'(mem_word(base + 32'(2 * v.rng))));
      end
    end

    // R5 attention ends burst early
    ext_dir = 0;
    setup(16'h0200, 15'h0, 16'd9, 6'h2A);
    run(0, -1, -1, 6, -1);
    check("R5 ready", 32'(ready), 1);
    check("R5 eor+attn", {30'd0, eor_flag, attn_flag}, 3);
    check("R5 cut short", 32'(r_words < 10), 1);

    // R8 timeout; R10 go cleared attention flag
    setup(16'h0300, 15'h0, 16'd2, 6'h11);
    run(1000, -1, -1, -1, -1);
    check("R8 tmo flag", 32'(tmo_flag), 1);
    check("R8 no eor", 32'(eor_flag), 0);
    check("R8 waiting cycles", r_vcyc, 64);
    check("R10 attn cleared by go", 32'(attn_flag), 0);

    // R9 bus error aborts
    setup(16'h0400, 15'h0, 16'd4, 6'h12);
    run(0, 1, -1, -1, -1);
    check("R9 berr flag", 32'(berr_flag), 1);
    check("R9 berr no eor", 32'(eor_flag), 0);
    check("R9 berr words", r_words, 1);
    check("R10 tmo cleared by go", 32'(tmo_flag), 0);

    // R9 parity continues
    setup(16'h0480, 15'h0, 16'd2, 6'h13);
    run(0, -1, 0, -1, -1);
    check("R9 perr flag", {30'd0, perr_flag, berr_flag}, 2);
    check("R9 perr eor", 32'(eor_flag), 1);
    check("R9 perr words", r_words, 3);

    // R10 go and writes ignored while busy
    ext_dir = 1;
    setup(16'h0500, 15'h0, 16'd3, 6'h15);
    run(0, -1, -1, -1, 3);
    check("R10 words unchanged", r_words, 4);
    check("R10 amod during burst", r_amod_err, 0);
    check("R10 amod after burst", 32'(mem_req_amod), 32'h15);

    // R4 link mode selects function latch
    link_mode = 1; fn1_latch = 1; ext_dir = 0;
    setup(16'h0600, 15'h0, 16'd1, 6'h01);
    run(0, -1, -1, -1, -1);
    check("R4 link input writes", r_wr, 2);
    check("R4 link input data", r_data_err, 0);
    fn1_latch = 0; ext_dir = 1;
    setup(16'h0700, 15'h0, 16'd1, 6'h01);
    run(0, -1, -1, -1, -1);
    check("R4 link output writes", r_wr, 0);
    check("R4 link output words", r_words, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule